// File: doc/BRIEF.md
# Four-Level Page Table Walker

The block turns a 48-bit virtual address into a 40-bit physical address. It walks a radix translation tree kept in memory, four tables deep, with 512 eight-byte entries in each table. A request carries the virtual address and the frame number of the process's top-level table. The walker then makes one dependent memory read per level. At each level it either takes the next table's frame from the entry or stops on an invalid entry. When it finishes it presents either the final frame joined to the untranslated 12-bit page offset, or a fault flag with the level at which the walk stopped.

The walker serves one request at a time and keeps at most one memory read in flight. It holds its result until the consumer accepts it and only then becomes ready for the next walk. It is meant to sit behind a translation cache that calls it on a miss. Large pages are not supported, and servicing a fault is left to software.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready_o` is 1 and both `mem_req_valid_o` and `rsp_valid_o` are 0.
- R2: A request is taken only when `req_ready_o` is 1. `req_ready_o` stays 0 from the accepting edge until the result handshake, so a request held valid during a walk is not taken.
- R3: Reads go out in the order level 4, 3, 2, 1. The level-k index is virtual bits [12+9(k-1) +: 9], so level 4 uses bits 47:39 and level 1 uses bits 20:12. Each read address is {table frame, 12'h000} + index*8. The level-4 table frame is `req_root_ppn_i`, and every lower table frame is bits 39:12 of the entry read one level up.
- R4: At most one memory read is outstanding. A `mem_rsp_valid_i` pulse that arrives when no read is pending is ignored and changes no output.
- R5: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays valid and `mem_req_addr_o` stays constant.
- R6: When all four entries are valid, the walk ends with `rsp_fault_o` = 0 and `rsp_paddr_o` = {leaf bits 39:12, virtual bits 11:0}.
- R7: On success the leaf entry's bits are reported as follows: bit 1 to `rsp_wr_o`, bit 2 to `rsp_usr_o`, bit 5 to `rsp_ref_o` and bit 6 to `rsp_mod_o`. Entry bits 63:40 and the other low bits have no effect.
- R8: An entry with bit 0 = 0 ends the walk with `rsp_fault_o` = 1. No further reads are issued, and `rsp_fault_lvl_o` gives the level where it happened (3 = level 4 ... 0 = level 1).
- R9: The result stays valid and unchanged until `rsp_ready_i` is 1. On the cycle after that handshake, `rsp_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 48 | Virtual address to translate |
| req_root_ppn_i | input | 28 | Frame number of the top-level table |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 40 | Physical address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Consumer accepts the result |
| rsp_fault_o | output | 1 | Walk ended on an invalid entry |
| rsp_fault_lvl_o | output | 2 | Level of the invalid entry (3 = top) |
| rsp_paddr_o | output | 40 | Translated physical address |
| rsp_wr_o | output | 1 | Leaf write permission |
| rsp_usr_o | output | 1 | Leaf user permission |
| rsp_ref_o | output | 1 | Leaf reference bit |
| rsp_mod_o | output | 1 | Leaf modify bit |

## Verification
Two events can land on the same edge. The consumer may accept a finished result while the next walk request is already waiting. A stray memory response may also arrive while the walker is idle or holding a result. The bench keeps `req_valid_i` high through an entire walk and checks that `req_ready_o` stays low until the cycle after the result handshake. It injects unsolicited response pulses carrying a valid-looking entry and then checks that the held result, the idle state and the next translation are unaffected. Each walk's read addresses and outcome are compared against a software model of the same tree.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 48;
  localparam int PA_W     = 40;
  localparam int PG_OFF_W = 12;
  localparam int IDX_W    = 9;
  localparam int LEVELS   = 4;
  localparam int ENT_W    = 64;
  localparam int ENT_SH   = 3;  // log2 of entry bytes
  localparam int PPN_W    = PA_W - PG_OFF_W;
  localparam int LVL_W    = $clog2(LEVELS);

  localparam int B_VALID = 0;
  localparam int B_WR    = 1;
  localparam int B_USR   = 2;
  localparam int B_REF   = 5;
  localparam int B_MOD   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L4, ST_L3, ST_L2, ST_L1, ST_DONE, ST_FAULT
  } walk_state_e;

  typedef struct packed {
    logic             valid;
    logic             wr;
    logic             usr;
    logic             ref_b;
    logic             mod;
    logic [PPN_W-1:0] ppn;
  } pte_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [PPN_W-1:0] base_ppn_i,
  output logic [PA_W-1:0]  entry_addr_o
);
  logic [IDX_W-1:0] idx_a [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_a[g] = vaddr_i[PG_OFF_W + g*IDX_W +: IDX_W];
  end

  assign idx_sel      = idx_a[lvl_i];
  assign entry_addr_o = {base_ppn_i, {PG_OFF_W{1'b0}}}
                      + PA_W'({idx_sel, {ENT_SH{1'b0}}});
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
(
  input  logic [ENT_W-1:0] raw_i,
  output pte_t             pte_o
);
  logic unused_bits;

  assign pte_o.valid = raw_i[B_VALID];
  assign pte_o.wr    = raw_i[B_WR];
  assign pte_o.usr   = raw_i[B_USR];
  assign pte_o.ref_b = raw_i[B_REF];
  assign pte_o.mod   = raw_i[B_MOD];
  assign pte_o.ppn   = raw_i[PG_OFF_W +: PPN_W];
  assign unused_bits = ^{raw_i[ENT_W-1:PA_W], raw_i[PG_OFF_W-1:B_MOD+1],
                         raw_i[B_REF-1:B_USR+1]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [PPN_W-1:0] req_root_ppn_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [ENT_W-1:0] mem_rsp_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_fault_o,
  output logic [LVL_W-1:0] rsp_fault_lvl_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_wr_o,
  output logic             rsp_usr_o,
  output logic             rsp_ref_o,
  output logic             rsp_mod_o
);
  walk_state_e      state_q, state_nxt_lvl;
  logic             pending_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [PPN_W-1:0] base_q;
  logic [LVL_W-1:0] cur_lvl, flt_lvl_q;
  logic             wr_q, usr_q, ref_q, mod_q;
  logic             walking, mem_fire, rsp_take;
  pte_t             pte;

  always_comb begin
    cur_lvl       = '0;
    state_nxt_lvl = ST_L1;
    unique case (state_q)
      ST_L4:   begin cur_lvl = LVL_W'(3); state_nxt_lvl = ST_L3; end
      ST_L3:   begin cur_lvl = LVL_W'(2); state_nxt_lvl = ST_L2; end
      ST_L2:   begin cur_lvl = LVL_W'(1); state_nxt_lvl = ST_L1; end
      default: ;
    endcase
  end

  assign walking  = (state_q == ST_L4) || (state_q == ST_L3)
                 || (state_q == ST_L2) || (state_q == ST_L1);
  assign mem_fire = mem_req_valid_o && mem_req_ready_i;
  // responses count only while a read is pending
  assign rsp_take = walking && pending_q && mem_rsp_valid_i;

  ptw_addr_gen u_addr_gen (
    .vaddr_i      (vaddr_q),
    .lvl_i        (cur_lvl),
    .base_ppn_i   (base_q),
    .entry_addr_o (mem_req_addr_o)
  );

  ptw_pte_decode u_pte_decode (
    .raw_i (mem_rsp_data_i),
    .pte_o (pte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pending_q <= 1'b0;
      vaddr_q   <= '0;
      base_q    <= '0;
      flt_lvl_q <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      ref_q     <= 1'b0;
      mod_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q   <= req_vaddr_i;
          base_q    <= req_root_ppn_i;
          pending_q <= 1'b0;
          state_q   <= ST_L4;
        end
        ST_L4, ST_L3, ST_L2, ST_L1: begin
          if (mem_fire) pending_q <= 1'b1;
          if (rsp_take) begin
            pending_q <= 1'b0;
            if (!pte.valid) begin
              state_q   <= ST_FAULT;
              flt_lvl_q <= cur_lvl;
              wr_q      <= 1'b0;
              usr_q     <= 1'b0;
              ref_q     <= 1'b0;
              mod_q     <= 1'b0;
            end else begin
              base_q <= pte.ppn;
              if (state_q == ST_L1) begin
                state_q   <= ST_DONE;
                flt_lvl_q <= '0;
                wr_q      <= pte.wr;
                usr_q     <= pte.usr;
                ref_q     <= pte.ref_b;
                mod_q     <= pte.mod;
              end else begin
                state_q <= state_nxt_lvl;
              end
            end
          end
        end
        ST_DONE, ST_FAULT: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = walking && !pending_q;
  assign rsp_valid_o     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault_o     = (state_q == ST_FAULT);
  assign rsp_fault_lvl_o = flt_lvl_q;
  assign rsp_paddr_o     = {base_q, vaddr_q[PG_OFF_W-1:0]};
  assign rsp_wr_o        = wr_q;
  assign rsp_usr_o       = usr_q;
  assign rsp_ref_o       = ref_q;
  assign rsp_mod_o       = mod_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import ptw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic             mem_rsp_valid_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic             rsp_fault_o,
  input logic [LVL_W-1:0] rsp_fault_lvl_o,
  input logic [PA_W-1:0]  rsp_paddr_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         out_q <= 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i) out_q <= 1'b1;
    else if (mem_rsp_valid_i)            out_q <= 1'b0;
  end

  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_valid_o) |-> !req_ready_o);

  a_r4_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> !mem_req_valid_o);

  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  a_r9_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_paddr_o)
      && $stable(rsp_fault_o) && $stable(rsp_fault_lvl_o)));

  a_r9_back_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |=> (req_ready_o && !rsp_valid_o));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_fault_lvl_o (rsp_fault_lvl_o),
  .rsp_paddr_o     (rsp_paddr_o)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [47:0] req_vaddr_i = '0;
  logic [27:0] req_root_ppn_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [39:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic        rsp_fault_o;
  logic [1:0]  rsp_fault_lvl_o;
  logic [39:0] rsp_paddr_o;
  logic        rsp_wr_o, rsp_usr_o, rsp_ref_o, rsp_mod_o;

  always #2 clk_i = ~clk_i;

  pt_walker dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] pmem [logic [39:0]];
  logic [39:0] obs_addr [int];
  int obs_n = 0;
  int spur_req_n = 0;
  logic [27:0] next_free = 28'h100;
  logic [39:0] exp_addr [int];
  int exp_n;
  bit e_fault;
  logic [1:0] e_lvl;
  logic [39:0] e_paddr;
  logic [3:0] e_flags;
  logic [47:0] map_va [int];
  logic [27:0] map_root [int];
  int map_n = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_rd(input logic [39:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 64'h0;
  endfunction

  function automatic logic [39:0] ent_addr(input logic [27:0] b, input logic [47:0] va, input int l);
    return {b, 12'h000} + 40'(va[12 + l*9 +: 9]) * 40'd8;
  endfunction

  // flags = {mod, ref, usr, wr}
  task automatic map_page(input logic [27:0] root, input logic [47:0] va,
                          input logic [27:0] leaf, input logic [3:0] flags, input bit v);
    logic [27:0] b = root;
    logic [39:0] a;
    for (int l = 3; l >= 1; l--) begin
      a = ent_addr(b, va, l);
      if (!pmem.exists(a) || !pmem[a][0]) begin
        pmem[a] = {24'h0, next_free, 12'h001};
        next_free++;
      end
      b = pmem[a][39:12];
    end
    a = ent_addr(b, va, 0);
    pmem[a] = {24'($urandom), leaf, 5'b0, flags[3], flags[2], 2'b0, flags[1], flags[0], v};
  endtask

  task automatic model_walk(input logic [27:0] root, input logic [47:0] va);
    logic [27:0] b = root;
    logic [63:0] e = '0;
    logic [39:0] a;
    exp_n = 0; e_fault = 0; e_lvl = '0; e_paddr = '0; e_flags = '0;
    for (int l = 3; l >= 0; l--) begin
      a = ent_addr(b, va, l);
      exp_addr[exp_n] = a;
      exp_n++;
      e = mem_rd(a);
      if (!e[0]) begin
        e_fault = 1; e_lvl = 2'(l);
        return;
      end
      b = e[39:12];
    end
    e_paddr = {b, va[11:0]};
    e_flags = {e[6], e[5], e[2], e[1]};
  endtask

  // memory model: random back-pressure and latency, optional stray responses
  initial begin : responder
    int spur_done_n = 0;
    bit prev_stall = 0;
    logic [39:0] prev_addr = '0;
    logic [39:0] a;
    forever begin
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
      if (prev_stall)
        check(mem_req_valid_o && (mem_req_addr_o == prev_addr), "R5 request held",
              {24'h0, mem_req_addr_o}, {24'h0, prev_addr});
      prev_stall = 0;
      if (spur_req_n != spur_done_n && !mem_req_valid_o) begin
        mem_req_ready_i = 1'b0;
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = 64'h0000_00AB_CDEF_F067;
        spur_done_n++;
      end else begin
        mem_req_ready_i = (($urandom % 4) != 0);
        if (mem_req_valid_o && !mem_req_ready_i) begin
          prev_stall = 1; prev_addr = mem_req_addr_o;
        end
        if (mem_req_valid_o && mem_req_ready_i) begin
          a = mem_req_addr_o;
          obs_addr[obs_n] = a;
          obs_n++;
          @(negedge clk_i);
          mem_req_ready_i = 1'b0;
          repeat ($urandom % 3) @(negedge clk_i);
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_rd(a);
        end
      end
    end
  end

  task automatic run_walk(input logic [27:0] root, input logic [47:0] va,
                          input int hold, input bit spur, input bit keep_req, input string tag);
    int base_n;
    bit busy_ok = 1, stab_ok = 1, addr_ok;
    logic [39:0] pa0;
    logic f0;
    model_walk(root, va);
    base_n = obs_n;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_root_ppn_i = root;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    if (keep_req) req_vaddr_i = ~va;
    else req_valid_i = 1'b0;
    while (!rsp_valid_o) begin
      if (req_ready_o) busy_ok = 0;
      @(negedge clk_i);
    end
    if (keep_req) check(busy_ok, "R2 no accept while busy", 64'(busy_ok), 64'd1);
    addr_ok = ((obs_n - base_n) == exp_n);
    for (int i = 0; i < exp_n && addr_ok; i++)
      if (obs_addr[base_n + i] != exp_addr[i]) addr_ok = 0;
    check(addr_ok, e_fault ? "R8 reads stop at fault" : "R3 read sequence",
          64'(obs_n - base_n), 64'(exp_n));
    check(rsp_fault_o == e_fault, {tag, " R8 fault flag"}, 64'(rsp_fault_o), 64'(e_fault));
    if (e_fault)
      check(rsp_fault_lvl_o == e_lvl, {tag, " R8 fault level"}, 64'(rsp_fault_lvl_o), 64'(e_lvl));
    else begin
      check(rsp_paddr_o == e_paddr, {tag, " R6 paddr"}, 64'(rsp_paddr_o), 64'(e_paddr));
      check({rsp_mod_o, rsp_ref_o, rsp_usr_o, rsp_wr_o} == e_flags, {tag, " R7 leaf bits"},
            64'({rsp_mod_o, rsp_ref_o, rsp_usr_o, rsp_wr_o}), 64'(e_flags));
    end
    pa0 = rsp_paddr_o; f0 = rsp_fault_o;
    for (int i = 0; i < hold; i++) begin
      if (spur && i == 0) spur_req_n++;
      @(negedge clk_i);
      if (!(rsp_valid_o && rsp_paddr_o == pa0 && rsp_fault_o == f0 && mem_req_valid_o == 0)) stab_ok = 0;
    end
    if (hold > 0) check(stab_ok, spur ? "R4 stray response while holding" : "R9 result held",
                        64'(rsp_paddr_o), 64'(pa0));
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    req_valid_i = 1'b0;
    check(!rsp_valid_o && req_ready_o, "R9 idle after handshake",
          64'({rsp_valid_o, req_ready_o}), 64'b01);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [47:0] va;
    logic [27:0] rt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R1 in reset",
          64'({req_ready_o, mem_req_valid_o, rsp_valid_o}), 64'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o && !mem_req_valid_o && !rsp_valid_o, "R1 after reset",
          64'({req_ready_o, mem_req_valid_o, rsp_valid_o}), 64'b100);

    // directed corners
    run_walk(28'h30, 48'h1234_5678_9ABC, 0, 0, 0, "empty root");
    map_page(28'h10, 48'h0000_4020_3005, 28'hABCDE12, 4'b1010, 1);
    run_walk(28'h10, 48'h0000_4020_3A5C, 0, 0, 0, "mapped");
    map_page(28'h10, 48'h0000_4020_4000, 28'h0000777, 4'b1111, 0);
    run_walk(28'h10, 48'h0000_4020_4FFF, 0, 0, 0, "invalid leaf");
    map_page(28'h10, 48'hFFFF_FFFF_FFFF, 28'hFFFFFFF, 4'b0101, 1);
    run_walk(28'h10, 48'hFFFF_FFFF_FFFF, 0, 0, 0, "top va");
    map_page(28'h10, 48'h0, 28'h0000001, 4'b0000, 1);
    run_walk(28'h10, 48'h0, 0, 0, 0, "zero va");
    spur_req_n++;
    repeat (4) @(negedge clk_i);
    check(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R4 stray response while idle",
          64'({req_ready_o, rsp_valid_o, mem_req_valid_o}), 64'b100);
    run_walk(28'h10, 48'h0000_4020_3123, 6, 1, 0, "stray in done");
    run_walk(28'h10, 48'h0000_4020_3777, 3, 0, 1, "held request");

    // random trees and walks
    for (int i = 0; i < 24; i++) begin
      rt = (i % 2) ? 28'h20 : 28'h10;
      va = {$urandom, $urandom} & 48'hFFFF_FFFF_F000;
      map_page(rt, va, 28'($urandom), 4'($urandom), 1);
      map_va[map_n] = va; map_root[map_n] = rt; map_n++;
    end
    for (int i = 0; i < 220; i++) begin
      int k = $urandom % map_n;
      int c = $urandom % 5;
      va = map_va[k] | 48'($urandom % 4096);
      if (c == 1) va[12 + ($urandom % 9)] ^= 1'b1;
      else if (c == 2) va[21 + ($urandom % 9)] ^= 1'b1;
      else if (c == 3) va = {$urandom, $urandom};
      run_walk(map_root[k], va, $urandom % 3, 0, ($urandom % 6) == 0, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule